// File: doc/BRIEF.md
# PCM Highway Time-Slot Port

This block is the slave end of a synchronous PCM highway. It carries one voice sample per frame in each direction. The bit clock and the frame strobe come from the highway master. Inside each frame, the block shifts a parallel transmit sample out on the serial output during a programmed window. During a second window, which is programmed separately, it gathers a serial receive sample from the input and presents it as a parallel word with a one-cycle valid strobe.

Both window positions are static 10-bit counts of bit-clock cycles measured from the frame strobe. Three static selects set the rest of the framing:
- A short strobe or a long strobe. With a short strobe, data starts one cycle later than with a long one.
- One bit-clock cycle per data bit, or two.
- 8-bit companded samples or 16-bit linear samples.

The serial output is meant for a shared line. The block produces a drive enable, and the pad ring places the line in high impedance whenever that enable is low.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, `dtx_oe`, `dtx`, `rx_valid` and `rx_sample` are all 0, and the output stays undriven until the first frame start.
- R2: A frame starts on the rising clock edge where `fsync` is sampled high after having been sampled low. Frame cycle n is the clock period that begins n edges after that one. The transmit slot begins in frame cycle `tx_start` when `long_fs`=1, and in cycle `tx_start`+1 when `long_fs`=0.
- R3: Samples are sent and received most significant bit first.
- R4: `dtx_oe` is 1 exactly during the transmit slot and 0 at all other times. While it is 1, `dtx` carries the current bit.
- R5: With `dbl_clk`=1, each bit occupies two consecutive cycles. The received bit is taken on the falling edge of the second of those two cycles.
- R6: With `wide`=0, a slot is 8 bits. The transmitted bits come from `tx_sample[7:0]`, and the received bits land in `rx_sample[7:0]` with the upper byte 0. With `wide`=1, a slot is 16 bits and uses the full word.
- R7: The receive slot is placed by `rx_start` under the same rule as R2, independently of `tx_start`. Single-clocked bits are sampled on the falling edge of their cycle. `rx_valid` is high for exactly one cycle: the frame cycle that directly follows the last cycle of the receive slot. `rx_sample` is updated in that same cycle.
- R8: `tx_sample` is captured at the frame start edge. Changes to it during the frame do not affect `dtx`.
- R9: A new frame start during a slot abandons that slot. No `rx_valid` is produced for the partial sample, and counting restarts from cycle 0.
- R10: Holding `fsync` high for several cycles, as the long strobe does, starts only one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame strobe |
| long_fs | input | 1 | 1: long strobe, data starts at the count itself; 0: short strobe, data starts one cycle later |
| dbl_clk | input | 1 | 1: two clock cycles per bit |
| wide | input | 1 | 1: 16-bit samples; 0: 8-bit samples |
| tx_start | input | 10 | Transmit slot offset in clock cycles |
| rx_start | input | 10 | Receive slot offset in clock cycles |
| tx_sample | input | 16 | Parallel transmit sample |
| drx | input | 1 | Serial receive data |
| dtx | output | 1 | Serial transmit data |
| dtx_oe | output | 1 | Drive enable for the transmit line |
| rx_sample | output | 16 | Last complete received sample |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_sample` |

## Verification
The assertions assume three things about the inputs: the framing selects and start counts are static while a frame is in progress, `fsync` is synchronous to the clock, and a long strobe drops low again before the next frame begins. The stimulus changes configuration only between frames. It sets and clears `fsync` just after a rising edge. It keeps every long strobe shorter than the gap to the next strobe, including in the abort case, where the strobe is raised again in the cycle before `rx_valid` would have appeared.

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int CNT_W    = 10,
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              long_fs,
  input  logic              dbl_clk,
  input  logic              wide,
  input  logic [CNT_W-1:0]  tx_start,
  input  logic [CNT_W-1:0]  rx_start,
  input  logic [WIDE_W-1:0] tx_sample,
  input  logic              drx,
  output logic              dtx,
  output logic              dtx_oe,
  output logic [WIDE_W-1:0] rx_sample,
  output logic              rx_valid
);
  localparam int FW = CNT_W + 2;
  localparam int BW = $clog2(WIDE_W);

  logic              fs_q, frame_on, drx_n;
  logic [FW-1:0]     cnt;
  logic [WIDE_W-1:0] tx_hold, rx_shift;

  wire          start   = fsync & ~fs_q;
  wire [FW-1:0] lead    = {{(FW-1){1'b0}}, ~long_fs};
  wire [FW-1:0] bits    = wide ? FW'(WIDE_W) : FW'(NARROW_W);
  wire [FW-1:0] span    = dbl_clk ? (bits << 1) : bits;

  wire [FW-1:0] tx_base = FW'(tx_start) + lead;
  wire [FW-1:0] tx_off  = cnt - tx_base;
  wire          tx_in   = frame_on && (cnt >= tx_base) && (tx_off < span);
  wire [FW-1:0] tx_idx  = dbl_clk ? (tx_off >> 1) : tx_off;
  wire [FW-1:0] tx_pos  = bits - 1'b1 - tx_idx;

  wire [FW-1:0] rx_base = FW'(rx_start) + lead;
  wire [FW-1:0] rx_off  = cnt - rx_base;
  wire          rx_in   = frame_on && (cnt >= rx_base) && (rx_off < span);
  wire [FW-1:0] rx_idx  = dbl_clk ? (rx_off >> 1) : rx_off;
  wire          rx_take = rx_in && (!dbl_clk || rx_off[0]);
  wire          rx_last = rx_take && (rx_idx == bits - 1'b1);

  assign dtx_oe = tx_in;
  assign dtx    = tx_in & tx_hold[tx_pos[BW-1:0]];

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) drx_n <= 1'b0;
    else        drx_n <= drx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q      <= 1'b0;
      frame_on  <= 1'b0;
      cnt       <= '0;
      tx_hold   <= '0;
      rx_shift  <= '0;
      rx_sample <= '0;
      rx_valid  <= 1'b0;
    end else begin
      fs_q     <= fsync;
      rx_valid <= 1'b0;
      if (start) begin
        frame_on <= 1'b1;
        cnt      <= '0;
        tx_hold  <= tx_sample;
        rx_shift <= '0;
      end else begin
        if (frame_on && cnt != {FW{1'b1}}) cnt <= cnt + 1'b1;
        if (rx_take) rx_shift <= {rx_shift[WIDE_W-2:0], drx_n};
        if (rx_last) begin
          rx_sample <= {rx_shift[WIDE_W-2:0], drx_n};
          rx_valid  <= 1'b1;
        end
      end
    end
  end

  AST_QUIET_BEFORE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |-> !dtx_oe); // R4
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7
  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> frame_on); // R7
  AST_HOLD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_hold) |-> $past(start)); // R8
  AST_ABORT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !rx_valid); // R9
  AST_LONG_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && fs_q) |=> cnt != '0); // R10
endmodule

// File: tb/tb_pcm_slot_port.sv
module tb_pcm_slot_port;
  logic clk = 0, rst_n = 0, fsync = 0, long_fs = 0, dbl_clk = 0, wide = 0, drx = 0;
  logic [9:0] tx_start = 0, rx_start = 0;
  logic [15:0] tx_sample = 0;
  logic dtx, dtx_oe, rx_valid;
  logic [15:0] rx_sample;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pcm_slot_port dut (.clk, .rst_n, .fsync, .long_fs, .dbl_clk, .wide, .tx_start,
    .rx_start, .tx_sample, .drx, .dtx, .dtx_oe, .rx_sample, .rx_valid);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int slot_base(input int start, input bit lf);
    return start + (lf ? 0 : 1);
  endfunction

  function automatic int bit_of(input logic [15:0] d, input int bits, input int off, input bit dc);
    return int'(d[bits - 1 - (dc ? off / 2 : off)]);
  endfunction

  function automatic logic [15:0] rx_expect(input logic [15:0] d, input bit wd);
    return wd ? d : {8'h00, d[7:0]};
  endfunction

  task automatic run_frame(input bit lf, input bit dc, input bit wd, input int ts, input int rs,
                           input logic [15:0] txd, input logic [15:0] rxd, input bit abort_it,
                           input logic [15:0] next_tx, input bit chain);
    int fsl  = lf ? 3 : 1;
    int bits = wd ? 16 : 8;
    int span = dc ? 2 * bits : bits;
    int tb   = slot_base(ts, lf);
    int rb   = slot_base(rs, lf);
    int last = abort_it ? rb + span - 1 : ((tb > rb ? tb : rb) + span + 2);
    if (!chain) begin
      long_fs = lf; dbl_clk = dc; wide = wd;
      tx_start = 10'(ts); rx_start = 10'(rs);
      @(posedge clk); #1;
      fsync = 1; tx_sample = txd;
    end
    for (int n = 0; n <= last; n++) begin
      int to, ro;
      bit exp_oe, exp_v;
      @(posedge clk); #1;
      fsync = (n + 1 < fsl);
      tx_sample = 16'($urandom);
      if (abort_it && n == last) begin fsync = 1; tx_sample = next_tx; end
      ro = n - rb;
      if (ro >= 0 && ro < span && (!dc || ro % 2 == 1)) drx = 1'(bit_of(rxd, bits, ro, dc));
      else drx = 1'($urandom);
      #1;
      to = n - tb;
      exp_oe = (to >= 0 && to < span);
      check(dtx_oe === exp_oe, "R2/R4 dtx_oe", int'(dtx_oe), int'(exp_oe));
      if (exp_oe)
        check(int'(dtx) == bit_of(txd, bits, to, dc), "R3/R5/R6/R8 dtx bit", int'(dtx),
              bit_of(txd, bits, to, dc));
      exp_v = (n == rb + span);
      check(rx_valid === exp_v, "R7/R9 rx_valid", int'(rx_valid), int'(exp_v));
      if (exp_v)
        check(rx_sample === rx_expect(rxd, wd), "R3/R5/R6/R7 rx_sample", int'(rx_sample),
              int'(rx_expect(rxd, wd)));
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5107));
    repeat (3) @(posedge clk);
    #1;
    check(dtx_oe === 0 && dtx === 0, "R1 reset dtx", int'({dtx_oe, dtx}), 0);
    check(rx_valid === 0 && rx_sample === 0, "R1 reset rx", int'(rx_sample), 0);
    rst_n = 1;
    repeat (4) begin
      @(posedge clk); #2;
      check(dtx_oe === 0, "R1 idle before frame", int'(dtx_oe), 0);
    end
    // directed corners: zero offsets, both strobe styles, R10 long hold
    run_frame(1, 0, 0, 0, 0, 16'h00A5, 16'h003C, 0, 0, 0);
    run_frame(0, 0, 0, 0, 0, 16'h005A, 16'h00C3, 0, 0, 0);
    run_frame(1, 0, 1, 3, 20, 16'h8001, 16'hF00D, 0, 0, 0);
    run_frame(0, 1, 1, 5, 5, 16'hBEEF, 16'h1234, 0, 0, 0);
    run_frame(1, 1, 0, 7, 2, 16'h1296, 16'h3469, 0, 0, 0);
    // R2/R7 maximum counts
    run_frame(1, 0, 1, 1023, 2, 16'hCAFE, 16'h7E81, 0, 0, 0);
    run_frame(0, 0, 0, 4, 1023, 16'h00FF, 16'hAB5A, 0, 0, 0);
    // R9 abort just before the receive slot completes, then a clean frame
    run_frame(0, 0, 1, 2, 6, 16'h1111, 16'h2222, 1, 16'h9C3E, 0);
    run_frame(0, 0, 1, 2, 6, 16'h9C3E, 16'h4D71, 0, 0, 1);
    run_frame(1, 1, 0, 1, 9, 16'h0033, 16'h0066, 1, 16'h00E7, 0);
    run_frame(1, 1, 0, 1, 9, 16'h00E7, 16'h0018, 0, 0, 1);
    // constrained random frames
    for (int i = 0; i < 40; i++)
      run_frame(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 40)),
                int'($urandom_range(0, 40)), 16'($urandom), 16'($urandom), 0, 0, 0);
    finish_up();
  end
endmodule